// File: doc/BRIEF.md
# Slot-timed power rail sequencer

This block switches a bank of power-rail enable outputs on and off in a timed order. Time is divided into slots. The slot period is a fixed number of reference clock cycles, set by a parameter; at the default setting of 125000 cycles of a 200 MHz clock, one slot lasts 625 µs. Every rail output has its own power-up slot and its own power-down slot. The two tables are independent, so the power-down order can differ from the reverse of the power-up order. Outputs that share a slot switch in the same clock cycle. A reset output is released a fixed delay after the last power-up slot; the default delay is 16 ms.

A second, smaller group of sleep-controlled outputs has its own entry and exit slot tables. A sleep request from the fully powered state switches this group off by the entry table. A wake request switches it back on by the exit table. During full power-up the group follows its exit table, and during power-down it follows its entry table, in step with the rail outputs. Slot tables are packed parameter vectors with SLOT_W bits per output, where output i occupies bits [i*SLOT_W +: SLOT_W]. Slot indices run from 0 to 2^SLOT_W-1.

A sequence ends with the highest slot index used by the tables it applies. A busy flag is high for as long as a sequence runs. A one-cycle done pulse marks the end of each sequence.

Top module: `rail_seq`

## Requirements
- R1: While rst_n is low, and right after it is released, all enable outputs are 0, rail_rst_n is 0, and seq_busy and seq_done are 0.
- R2: When a power-up request is accepted at clock edge k, slot s is applied at edge k+1+s*PRESC. At that edge every rail output whose up-slot is s goes to 1. Slot 0 is applied at edge k+1.
- R3: Outputs that share a slot index change in the same clock cycle.
- R4: In a power-down sequence, each rail output goes to 0 at the edge that applies its own down-slot. This uses the same slot timing as R2 and does not depend on the up-slot order.
- R5: rail_rst_n stays 0 through power-up. It goes to 1 exactly RST_CYC edges after the edge that applies the last up-slot. It goes back to 0 at the edge that accepts a power-down request.
- R6: seq_busy is 1 from the acceptance edge until the edge that applies the last slot of the running sequence. The last slot is the largest index in the tables that sequence uses. At that edge seq_busy goes to 0 and seq_done goes to 1 for exactly one cycle.
- R7: The sleep outputs clear by their entry slots when sleep_req is accepted, and set by their exit slots when wake_req is accepted. Both transitions leave pwr_en and rail_rst_n unchanged. Power-up applies the exit table to this group, and power-down applies the entry table.
- R8: Requests that are not valid in the present state are ignored. up_req is accepted only when fully off. sleep_req is accepted only when fully on. wake_req is accepted only when asleep. down_req is ignored when off or already powering down. No request other than down_req is accepted while seq_busy is 1.
- R9: A power-down request accepted during power-up or during a sleep transition aborts that sequence. Down-table slot 0 is then applied at the next edge, and outputs switched on so far are cleared by their down/entry slots.
- R10: When down_req and sleep_req arrive together in the fully-on state, the power-down sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Power-up request, sampled each edge |
| down_req | input | 1 | Power-down request, highest priority |
| sleep_req | input | 1 | Sleep entry request |
| wake_req | input | 1 | Sleep exit request |
| pwr_en | output | N_PWR | Rail enable outputs |
| slp_en | output | N_SLP | Sleep-group enable outputs |
| rail_rst_n | output | 1 | Active-low system reset output |
| seq_busy | output | 1 | A sequence is running |
| seq_done | output | 1 | One-cycle pulse at the end of each sequence |

## Verification
The bench builds the block with PRESC=4 and RST_CYC=6, so every slot boundary and the whole reset delay fit into a few dozen cycles. It uses four rail outputs: two share up-slot 2 and two share down-slot 3, and the down order is not the reverse of the up order. Two sleep outputs have exit slots 0 and 2 and entry slots 1 and 0. With these settings the four sequences end at different slots (5, 3, 1 and 2). That makes the end-of-sequence rule, the abort points between slot boundaries and the priority of power-down over sleep entry visible at the ports.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
   typedef enum logic [2:0] {
      PH_OFF   = 3'd0,
      PH_UP    = 3'd1,
      PH_ON    = 3'd2,
      PH_SENT  = 3'd3,
      PH_SLEEP = 3'd4,
      PH_SEXT  = 3'd5,
      PH_DN    = 3'd6
   } phase_e;
endpackage

// File: rtl/rseq_presc.sv
module rseq_presc #(
   parameter int PRESC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic first,
   output logic wrap
);
   if (PRESC == 1) begin : g_unit
      assign first = 1'b1;
      assign wrap  = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(PRESC);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt <= '0;
         else if (restart)  cnt <= '0;
         else if (run)      cnt <= (cnt == CW'(PRESC - 1)) ? '0 : cnt + 1'b1;
         else               cnt <= '0;
      end
      assign first = (cnt == '0);
      assign wrap  = (cnt == CW'(PRESC - 1));
   end
endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
   import rseq_pkg::*;
#(
   parameter int SLOT_W    = 3,
   parameter int LAST_UP   = 0,
   parameter int LAST_DN   = 0,
   parameter int LAST_SENT = 0,
   parameter int LAST_SEXT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_req,
   input  logic              down_req,
   input  logic              sleep_req,
   input  logic              wake_req,
   input  logic              first,
   input  logic              wrap,
   output phase_e            phase,
   output logic [SLOT_W-1:0] cur,
   output logic              proc,
   output logic              restart,
   output logic              busy,
   output logic              up_fin,
   output logic              dn_acc,
   output logic              done
);
   logic              up_acc, slp_acc, wk_acc, fin;
   logic [SLOT_W-1:0] last_cur;

   assign busy    = (phase == PH_UP) || (phase == PH_DN) ||
                    (phase == PH_SENT) || (phase == PH_SEXT);
   assign dn_acc  = down_req && (phase != PH_OFF) && (phase != PH_DN);
   assign up_acc  = up_req && (phase == PH_OFF);
   assign slp_acc = sleep_req && !down_req && (phase == PH_ON);
   assign wk_acc  = wake_req && !down_req && (phase == PH_SLEEP);
   assign restart = dn_acc || up_acc || slp_acc || wk_acc;
   assign proc    = busy && first && !dn_acc;

   always_comb begin
      unique case (phase)
         PH_UP:   last_cur = SLOT_W'(LAST_UP);
         PH_DN:   last_cur = SLOT_W'(LAST_DN);
         PH_SENT: last_cur = SLOT_W'(LAST_SENT);
         PH_SEXT: last_cur = SLOT_W'(LAST_SEXT);
         default: last_cur = '0;
      endcase
   end

   assign fin    = proc && (cur == last_cur);
   assign up_fin = fin && (phase == PH_UP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_OFF;
         cur   <= '0;
         done  <= 1'b0;
      end else begin
         done <= fin;
         if (dn_acc) begin
            phase <= PH_DN;
            cur   <= '0;
         end else if (up_acc) begin
            phase <= PH_UP;
            cur   <= '0;
         end else if (slp_acc) begin
            phase <= PH_SENT;
            cur   <= '0;
         end else if (wk_acc) begin
            phase <= PH_SEXT;
            cur   <= '0;
         end else if (fin) begin
            cur <= '0;
            unique case (phase)
               PH_UP:   phase <= PH_ON;
               PH_SENT: phase <= PH_SLEEP;
               PH_SEXT: phase <= PH_ON;
               default: phase <= PH_OFF;
            endcase
         end else if (busy && wrap) begin
            cur <= cur + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rseq_lanes.sv
module rseq_lanes #(
   parameter int                    N_LANE    = 2,
   parameter int                    SLOT_W    = 3,
   parameter logic [N_LANE*SLOT_W-1:0] SET_SLOTS = '0,
   parameter logic [N_LANE*SLOT_W-1:0] CLR_SLOTS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [SLOT_W-1:0] cur,
   output logic [N_LANE-1:0] en
);
   for (genvar i = 0; i < N_LANE; i++) begin : g_lane
      localparam logic [SLOT_W-1:0] S_ON  = SET_SLOTS[i*SLOT_W +: SLOT_W];
      localparam logic [SLOT_W-1:0] S_OFF = CLR_SLOTS[i*SLOT_W +: SLOT_W];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          en[i] <= 1'b0;
         else if (set_en && (cur == S_ON))    en[i] <= 1'b1;
         else if (clr_en && (cur == S_OFF))   en[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/rseq_rstdly.sv
module rseq_rstdly #(
   parameter int RST_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   output logic rel
);
   localparam int CW = $clog2(RST_CYC + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         rel <= 1'b0;
      end else if (abort) begin
         cnt <= '0;
         rel <= 1'b0;
      end else if (start) begin
         cnt <= CW'(RST_CYC);
      end else if (cnt == CW'(1)) begin
         cnt <= '0;
         rel <= 1'b1;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/rail_seq.sv
module rail_seq
   import rseq_pkg::*;
#(
   parameter int N_PWR   = 4,
   parameter int N_SLP   = 2,
   parameter int SLOT_W  = 3,
   parameter int PRESC   = 125000,
   parameter int RST_CYC = 3200000,
   parameter logic [N_PWR*SLOT_W-1:0] UP_SLOTS   = {3'd4, 3'd1, 3'd1, 3'd0},
   parameter logic [N_PWR*SLOT_W-1:0] DN_SLOTS   = {3'd0, 3'd2, 3'd2, 3'd4},
   parameter logic [N_SLP*SLOT_W-1:0] ENT_SLOTS  = {3'd3, 3'd0},
   parameter logic [N_SLP*SLOT_W-1:0] EXIT_SLOTS = {3'd0, 3'd1}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_req,
   input  logic             down_req,
   input  logic             sleep_req,
   input  logic             wake_req,
   output logic [N_PWR-1:0] pwr_en,
   output logic [N_SLP-1:0] slp_en,
   output logic             rail_rst_n,
   output logic             seq_busy,
   output logic             seq_done
);
   if (N_PWR < 1)                   begin : g_bad_npwr  $error("N_PWR must be at least 1");      end
   if (N_SLP < 1)                   begin : g_bad_nslp  $error("N_SLP must be at least 1");      end
   if (SLOT_W < 1 || SLOT_W > 8)    begin : g_bad_slotw $error("SLOT_W must be 1..8");           end
   if (PRESC < 1)                   begin : g_bad_presc $error("PRESC must be at least 1");      end
   if (RST_CYC < 1)                 begin : g_bad_rst   $error("RST_CYC must be at least 1");    end

   function automatic int hi_slot(input logic [N_PWR*SLOT_W-1:0] a, input bit use_a,
                                  input logic [N_SLP*SLOT_W-1:0] b, input bit use_b);
      int m = 0;
      if (use_a)
         for (int i = 0; i < N_PWR; i++)
            if (int'(a[i*SLOT_W +: SLOT_W]) > m) m = int'(a[i*SLOT_W +: SLOT_W]);
      if (use_b)
         for (int i = 0; i < N_SLP; i++)
            if (int'(b[i*SLOT_W +: SLOT_W]) > m) m = int'(b[i*SLOT_W +: SLOT_W]);
      return m;
   endfunction

   localparam int LAST_UP   = hi_slot(UP_SLOTS, 1'b1, EXIT_SLOTS, 1'b1);
   localparam int LAST_DN   = hi_slot(DN_SLOTS, 1'b1, ENT_SLOTS,  1'b1);
   localparam int LAST_SENT = hi_slot(DN_SLOTS, 1'b0, ENT_SLOTS,  1'b1);
   localparam int LAST_SEXT = hi_slot(UP_SLOTS, 1'b0, EXIT_SLOTS, 1'b1);

   phase_e            phase;
   logic [SLOT_W-1:0] cur;
   logic              first, wrap, proc, restart, up_fin, dn_acc;
   logic              pwr_set, pwr_clr, slp_set, slp_clr;

   rseq_presc #(.PRESC(PRESC)) u_presc (
      .clk(clk), .rst_n(rst_n), .restart(restart), .run(seq_busy),
      .first(first), .wrap(wrap)
   );

   rseq_ctrl #(
      .SLOT_W(SLOT_W), .LAST_UP(LAST_UP), .LAST_DN(LAST_DN),
      .LAST_SENT(LAST_SENT), .LAST_SEXT(LAST_SEXT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
      .sleep_req(sleep_req), .wake_req(wake_req), .first(first), .wrap(wrap),
      .phase(phase), .cur(cur), .proc(proc), .restart(restart), .busy(seq_busy),
      .up_fin(up_fin), .dn_acc(dn_acc), .done(seq_done)
   );

   assign pwr_set = proc && (phase == PH_UP);
   assign pwr_clr = proc && (phase == PH_DN);
   assign slp_set = proc && ((phase == PH_UP) || (phase == PH_SEXT));
   assign slp_clr = proc && ((phase == PH_DN) || (phase == PH_SENT));

   rseq_lanes #(
      .N_LANE(N_PWR), .SLOT_W(SLOT_W), .SET_SLOTS(UP_SLOTS), .CLR_SLOTS(DN_SLOTS)
   ) u_pwr (
      .clk(clk), .rst_n(rst_n), .set_en(pwr_set), .clr_en(pwr_clr), .cur(cur), .en(pwr_en)
   );

   rseq_lanes #(
      .N_LANE(N_SLP), .SLOT_W(SLOT_W), .SET_SLOTS(EXIT_SLOTS), .CLR_SLOTS(ENT_SLOTS)
   ) u_slp (
      .clk(clk), .rst_n(rst_n), .set_en(slp_set), .clr_en(slp_clr), .cur(cur), .en(slp_en)
   );

   rseq_rstdly #(.RST_CYC(RST_CYC)) u_rst (
      .clk(clk), .rst_n(rst_n), .start(up_fin), .abort(dn_acc), .rel(rail_rst_n)
   );
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
   parameter int N_PWR = 4,
   parameter int N_SLP = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             up_req,
   input logic             down_req,
   input logic             sleep_req,
   input logic             wake_req,
   input logic [N_PWR-1:0] pwr_en,
   input logic [N_SLP-1:0] slp_en,
   input logic             rail_rst_n,
   input logic             seq_busy,
   input logic             seq_done
);
   logic any_req;
   assign any_req = up_req | down_req | sleep_req | wake_req;

   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (pwr_en == '0 && slp_en == '0 && !rail_rst_n && !seq_busy && !seq_done));

   // R6
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   // R6
   a_r6_done_ends_seq: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> (!seq_busy && $past(seq_busy)));

   // R5
   a_r5_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_rst_n) |-> !seq_busy);

   // R5
   a_r5_drop_on_down: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rail_rst_n) |-> (seq_busy && $past(down_req)));

   // R2, R4
   a_r2_pwr_moves_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwr_en) |-> $past(seq_busy));

   // R7
   a_r7_slp_moves_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(slp_en) |-> $past(seq_busy));

   // R8
   a_r8_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_busy) |-> $past(any_req));
endmodule

bind rail_seq rail_seq_chk #(.N_PWR(N_PWR), .N_SLP(N_SLP)) u_chk (
   .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
   .sleep_req(sleep_req), .wake_req(wake_req), .pwr_en(pwr_en), .slp_en(slp_en),
   .rail_rst_n(rail_rst_n), .seq_busy(seq_busy), .seq_done(seq_done)
);

// File: tb/sim_rail_seq.sv
`timescale 1ns/1ps
module sim_rail_seq;
   localparam int P  = 4;
   localparam int RC = 6;
   localparam int K_UP = 0, K_DN = 1, K_SENT = 2, K_SEXT = 3;

   // bit i of each table: up {0,2,2,5}, down {3,0,1,3}, entry {1,0}, exit {0,2}
   int up_s[4]  = '{0, 2, 2, 5};
   int dn_s[4]  = '{3, 0, 1, 3};
   int ent_s[2] = '{1, 0};
   int ext_s[2] = '{0, 2};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_req = 1'b0, down_req = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
   logic [3:0] pwr_en;
   logic [1:0] slp_en;
   logic rail_rst_n, seq_busy, seq_done;

   int checks = 0, errs = 0;
   logic [3:0] epwr = '0;
   logic [1:0] eslp = '0;

   always #2.5 clk = ~clk;

   rail_seq #(
      .N_PWR(4), .N_SLP(2), .SLOT_W(3), .PRESC(P), .RST_CYC(RC),
      .UP_SLOTS({3'd5, 3'd2, 3'd2, 3'd0}), .DN_SLOTS({3'd3, 3'd1, 3'd0, 3'd3}),
      .ENT_SLOTS({3'd0, 3'd1}), .EXIT_SLOTS({3'd2, 3'd0})
   ) u0 (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
      .sleep_req(sleep_req), .wake_req(wake_req), .pwr_en(pwr_en), .slp_en(slp_en),
      .rail_rst_n(rail_rst_n), .seq_busy(seq_busy), .seq_done(seq_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic int last_of(input int kind);
      int m = 0;
      if (kind == K_UP || kind == K_DN)
         for (int i = 0; i < 4; i++) begin
            int v = (kind == K_UP) ? up_s[i] : dn_s[i];
            if (v > m) m = v;
         end
      for (int i = 0; i < 2; i++) begin
         int v = (kind == K_UP || kind == K_SEXT) ? ext_s[i] : ent_s[i];
         if (v > m) m = v;
      end
      return m;
   endfunction

   task automatic check_outs(input string req, input string what);
      chk(pwr_en == epwr, req, {what, " pwr_en"}, 32'(pwr_en), 32'(epwr));
      chk(slp_en == eslp, req, {what, " slp_en"}, 32'(slp_en), 32'(eslp));
   endtask

   task automatic accept(input int kind, input bit with_sleep);
      case (kind)
         K_UP:    up_req = 1'b1;
         K_DN:    down_req = 1'b1;
         K_SENT:  sleep_req = 1'b1;
         default: wake_req = 1'b1;
      endcase
      if (with_sleep) sleep_req = 1'b1;
      step();
      up_req = 1'b0; down_req = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
      chk(seq_busy == 1'b1, "R6", "busy after accept", 32'(seq_busy), 1);
      chk(seq_done == 1'b0, "R6", "done after accept", 32'(seq_done), 0);
      check_outs("R2", "unchanged at accept");
      if (kind == K_DN)
         chk(rail_rst_n == 1'b0, "R5", "reset drops on down", 32'(rail_rst_n), 0);
   endtask

   // Follows a running sequence edge by edge; stop>0 ends early, poke>0 injects ignored requests.
   task automatic run(input int kind, input int stop, input int poke);
      int last = last_of(kind);
      bit ended = 1'b0;
      for (int e = 1; e < 200 && !ended; e++) begin
         bit slot_edge = ((e - 1) % P == 0);
         int s = (e - 1) / P;
         step();
         if (e == poke + 1 && poke > 0) begin
            up_req = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
         end
         if (slot_edge) begin
            for (int i = 0; i < 4; i++) begin
               if (kind == K_UP && up_s[i] == s) epwr[i] = 1'b1;
               if (kind == K_DN && dn_s[i] == s) epwr[i] = 1'b0;
            end
            for (int i = 0; i < 2; i++) begin
               if ((kind == K_UP || kind == K_SEXT) && ext_s[i] == s) eslp[i] = 1'b1;
               if ((kind == K_DN || kind == K_SENT) && ent_s[i] == s) eslp[i] = 1'b0;
            end
         end
         case (kind)
            K_UP:    check_outs("R2 R3", "power-up slot");
            K_DN:    check_outs("R4 R3", "power-down slot");
            default: check_outs("R7", "sleep slot");
         endcase
         if (kind == K_SENT || kind == K_SEXT)
            chk(rail_rst_n == 1'b1, "R7", "reset kept in sleep move", 32'(rail_rst_n), 1);
         else
            chk(rail_rst_n == 1'b0, "R5", "reset held in sequence", 32'(rail_rst_n), 0);
         if (slot_edge && s == last) begin
            chk(seq_busy == 1'b0, "R6", "busy at last slot", 32'(seq_busy), 0);
            chk(seq_done == 1'b1, "R6", "done at last slot", 32'(seq_done), 1);
            ended = 1'b1;
         end else begin
            chk(seq_busy == 1'b1, "R6", "busy mid sequence", 32'(seq_busy), 1);
            chk(seq_done == 1'b0, "R6", "done mid sequence", 32'(seq_done), 0);
         end
         if (e == poke) begin   // R8: same-direction and sleep requests while busy
            up_req = 1'b1; sleep_req = 1'b1; wake_req = 1'b1;
         end
         if (stop > 0 && e == stop) ended = 1'b1;
      end
   endtask

   task automatic wait_release();
      for (int j = 1; j <= RC; j++) begin
         step();
         chk(rail_rst_n == (j == RC), "R5", "reset delay", 32'(rail_rst_n), 32'(j == RC));
         if (j == 1) chk(seq_done == 1'b0, "R6", "done is one cycle", 32'(seq_done), 0);
      end
   endtask

   task automatic t_reset();
      repeat (3) step();
      check_outs("R1", "in reset");
      chk(rail_rst_n == 1'b0, "R1", "reset out in reset", 32'(rail_rst_n), 0);
      rst_n = 1'b1;
      step();
      check_outs("R1", "after reset");
      chk({seq_busy, seq_done, rail_rst_n} == 3'b000, "R1", "flags after reset",
          32'({seq_busy, seq_done, rail_rst_n}), 0);
   endtask

   task automatic t_idle_ignore();
      down_req = 1'b1; sleep_req = 1'b1; wake_req = 1'b1;
      step();
      down_req = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
      repeat (P + 2) step();
      chk(seq_busy == 1'b0, "R8", "requests ignored when off", 32'(seq_busy), 0);
      check_outs("R8", "off state untouched");
   endtask

   task automatic t_power_up();
      accept(K_UP, 1'b0);
      run(K_UP, 0, 7);
      wait_release();
   endtask

   task automatic t_sleep_cycle();
      accept(K_SENT, 1'b0);
      run(K_SENT, 0, 0);
      sleep_req = 1'b1;
      step();
      sleep_req = 1'b0;
      repeat (P) step();
      chk(seq_busy == 1'b0, "R8", "sleep_req ignored when asleep", 32'(seq_busy), 0);
      check_outs("R7", "asleep state");
      accept(K_SEXT, 1'b0);
      run(K_SEXT, 0, 3);
      chk(pwr_en == 4'hF, "R7", "rails kept through sleep", 32'(pwr_en), 32'hF);
   endtask

   task automatic t_down_priority();
      accept(K_DN, 1'b1);   // R10: sleep_req arrives together with down_req
      run(K_DN, 0, 6);
      chk({pwr_en, slp_en} == 6'b0, "R10", "down wins, all off", 32'({pwr_en, slp_en}), 0);
   endtask

   task automatic t_abort_up();
      accept(K_UP, 1'b0);
      run(K_UP, 6, 0);
      accept(K_DN, 1'b0);   // R9: aborts before up-slot 2
      run(K_DN, 0, 0);
      chk({pwr_en, slp_en} == 6'b0, "R9", "aborted up ends off", 32'({pwr_en, slp_en}), 0);
   endtask

   task automatic t_abort_sleep();
      accept(K_UP, 1'b0);
      run(K_UP, 0, 0);
      wait_release();
      accept(K_SENT, 1'b0);
      run(K_SENT, 3, 0);
      accept(K_DN, 1'b0);   // R9: aborts sleep entry before entry slot 1
      run(K_DN, 0, 0);
      chk({pwr_en, slp_en} == 6'b0, "R9", "aborted sleep ends off", 32'({pwr_en, slp_en}), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL R6 watchdog: actual=20000 cycles expected=fewer");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin : main
      #1;
      t_reset();
      t_idle_ignore();
      t_power_up();
      t_sleep_cycle();
      t_down_priority();
      t_abort_up();
      t_abort_sleep();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule